// File: doc/BRIEF.md
# I2C Master Command Queue Sequencer

This block is the transaction engine of an I2C master. A host writes 9-bit command words into a 16-entry command queue. Each word either carries a byte to transmit or asks for one byte to be received. The engine takes the words in order and produces the bus sequence for them: START, the address byte, data bytes, acknowledge slots, repeated START on a change of direction, and STOP. Received bytes go into a 16-entry receive queue, which the host drains through the same data register it uses to push commands.

Bit-level SCL/SDA timing is outside the block. An external timer pulses `bit_tick` once per bus slot. On a tick the engine either emits one bus symbol on `bus_stb`/`bus_sym`/`bus_bit` or stays silent. For sample slots it reads `sda_in` in the same tick. A stop-hold control lets the master keep the bus after the queue runs dry, so that a slow host can extend a transfer without losing the bus. The enable register is handshaked: software writes it and then polls a separate status register until that register follows.

The register map, by word address on `reg_addr`: 0 control, 1 target address, 2 data/command, 3 enable request, 4 enable status, 5 status, 6 event flags. Reads are combinational on `reg_rdata`. A read of address 2 or address 6 has a side effect at the clock edge where `reg_rd` is high.

Top module: `i2cq_master`

## Requirements
- R1: After reset, status (address 5) reads 0x006: command queue empty (bit 2) and not full (bit 1), all other bits clear. Enable status and event flags both read 0.
- R2: The enable status (address 4, bit 0) follows a write to the enable request (address 3, bit 0) only after EN_LAT clock cycles. It never follows in the cycle right after the write. A request to disable takes effect only once the engine is idle, that is, after its STOP.
- R3: Command word bit 8 = 1 requests one read byte; bit 8 = 0 transmits bits 7:0. The bus symbols are `bus_sym` 1 = START, 2 = repeated START, 3 = drive (`bus_bit` is the level), 4 = sample (`sda_in` is read), 5 = STOP. `bus_stb` is high only in a `bit_tick` cycle. A transaction begins with START and then the address byte MSB first, ending with the R/W bit (1 = read). Written bytes go out MSB first. Each byte from master to slave is followed by one sample slot in which `sda_in` = 0 is ACK.
- R4: The command queue holds 16 words. A push while it is full drops the word and sets flag bit 0 (address 6). Status bit 1 is "not full" and status bit 2 is "empty".
- R5: A read byte takes 8 sample slots, MSB first, and then enters the receive queue. Reading address 2 returns the oldest byte in bits 7:0 and removes it. Status bit 3 is set while the receive queue holds data.
- R6: After a read byte, the master drives its acknowledge slot to 0 if the next queued word is a read. It drives 1 (NACK) if the queue is empty or the next word is a write.
- R7: When the next word's direction differs from the current one, control bit 5 set gives a repeated START and a new address byte. Control bit 5 clear gives STOP, then START, then a new address byte.
- R8: With control bit 7 clear, an empty queue ends the transfer with STOP. With it set, the bus is held with no symbols, and words pushed later continue the same transfer. Clearing the bit (or requesting disable) then produces the STOP. Status bit 5 is high from START until that STOP.
- R9: A NACK in the sample slot after the address or after a written byte flushes the command queue, sets flag bit 2 and ends with STOP.
- R10: A byte received while the receive queue is full is dropped and sets flag bit 1. The 16 queued bytes stay intact.
- R11: Only the low 7 bits of the target register (address 1) form the slave address on the bus.
- R12: No transfer starts unless control bit 0 and the enable status are both set. Reading address 6 returns the flags and clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data, clears flags) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 9 | Write data; 9 bits for command words |
| reg_rdata | output | 16 | Read data for reg_addr |
| bit_tick | input | 1 | One pulse per bus slot from the bit timer |
| sda_in | input | 1 | Bus data level sampled in sample slots |
| bus_stb | output | 1 | A bus symbol is emitted this cycle |
| bus_sym | output | 3 | Symbol code (see R3) |
| bus_bit | output | 1 | Level for drive slots |

## Verification
Randomly generated command lists of one to six words, mixing write and read words, are played once with repeated START enabled and once with it disabled. This tells apart the direction-change handling, the ACK/NACK choice after a read that depends on the next word, and the address R/W bit. Directed runs cover the other cases. A queue filled with the engine switched off separates dropped from kept words, because the transfer that follows must carry exactly the first 16. A slave NACK is placed once on the address and once on a data byte, to show the flush and STOP from both slots. A stop-hold run, with late pushes and a disable issued while the bus is held, shows that the bus is kept and then released only through its own STOP. A 17th received byte shows that the receive queue keeps its older contents.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_SEL, ST_WDATA,
    ST_WACK, ST_RDATA, ST_MACK, ST_RSTART, ST_STOP
  } eng_state_t;

  typedef enum logic [2:0] {
    SYM_NONE    = 3'd0,
    SYM_START   = 3'd1,
    SYM_RESTART = 3'd2,
    SYM_DRIVE   = 3'd3,
    SYM_SAMPLE  = 3'd4,
    SYM_STOP    = 3'd5
  } bus_sym_t;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_TARGET = 3'd1;
  localparam logic [2:0] A_DATA   = 3'd2;
  localparam logic [2:0] A_ENABLE = 3'd3;
  localparam logic [2:0] A_ENSTAT = 3'd4;
  localparam logic [2:0] A_STATUS = 3'd5;
  localparam logic [2:0] A_FLAGS  = 3'd6;

  localparam int C_MASTER   = 0;
  localparam int C_RESTART  = 5;
  localparam int C_STOPHOLD = 7;

  // address byte on the wire: 7-bit slave address then R/W (1 = read)
  function automatic logic [7:0] addr_byte(input logic [7:0] tar, input logic rd);
    return {tar[6:0], rd};
  endfunction

  // master acknowledge level after a read byte: NACK unless another read follows
  function automatic logic master_nack(input logic q_empty, input logic [8:0] next_cmd);
    return q_empty | ~next_cmd[8];
  endfunction

endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  input  logic         flush,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign dout  = mem[rp[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else if (flush) begin
      rp <= wp;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full && !flush) mem[wp[AW-1:0]] <= din;
  end
endmodule

// File: rtl/i2cq_en_sync.sv
module i2cq_en_sync #(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  input  logic busy,
  output logic en_stat
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt;
  logic          pending;

  // a disable waits for the engine to finish its transfer
  assign pending = (en_req != en_stat) && (en_req || !busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      en_stat <= 1'b0;
    end else if (pending) begin
      if (cnt == CW'(LAT - 1)) begin
        en_stat <= en_req;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end
endmodule

// File: rtl/i2cq_engine.sv
module i2cq_engine
  import i2cq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       hold_en,
  input  logic       restart_en,
  input  logic       tick,
  input  logic       sda_in,
  input  logic [7:0] tar,
  input  logic       cmd_empty,
  input  logic [8:0] cmd_head,
  output logic       cmd_pop,
  output logic       abort_evt,
  output logic       rx_push,
  output logic [7:0] rx_byte,
  output logic       busy,
  output logic       bus_stb,
  output logic [2:0] bus_sym,
  output logic       bus_bit
);
  eng_state_t st;
  logic [2:0] bitcnt;
  logic [7:0] sh;
  logic       cur_rd;
  bus_sym_t   sym;
  logic       start_evt, same_dir, ack_slot, nack_lvl;

  assign start_evt = (st == ST_IDLE) && tick && go && !cmd_empty;
  assign same_dir  = (cmd_head[8] == cur_rd);
  assign ack_slot  = (st == ST_AACK) || (st == ST_WACK);
  assign abort_evt = ack_slot && tick && sda_in;
  assign nack_lvl  = master_nack(cmd_empty, cmd_head);
  assign rx_push   = (st == ST_MACK) && tick;
  assign rx_byte   = sh;
  assign cmd_pop   = (st == ST_SEL) && !cmd_empty && same_dir;
  assign busy      = (st != ST_IDLE);

  always_comb begin
    sym     = SYM_NONE;
    bus_bit = 1'b1;
    unique case (st)
      ST_IDLE:   if (start_evt) sym = SYM_START;
      ST_RSTART: if (tick) sym = SYM_RESTART;
      ST_ADDR, ST_WDATA: if (tick) begin
        sym     = SYM_DRIVE;
        bus_bit = sh[7];
      end
      ST_AACK, ST_WACK, ST_RDATA: if (tick) sym = SYM_SAMPLE;
      ST_MACK: if (tick) begin
        sym     = SYM_DRIVE;
        bus_bit = nack_lvl;
      end
      ST_STOP:   if (tick) sym = SYM_STOP;
      default:   sym = SYM_NONE;
    endcase
  end

  assign bus_stb = (sym != SYM_NONE);
  assign bus_sym = sym;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      bitcnt <= '0;
      sh     <= '0;
      cur_rd <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start_evt) begin
          st     <= ST_ADDR;
          cur_rd <= cmd_head[8];
          sh     <= addr_byte(tar, cmd_head[8]);
          bitcnt <= '0;
        end
        ST_RSTART: if (tick) begin
          st     <= ST_ADDR;
          cur_rd <= cmd_head[8];
          sh     <= addr_byte(tar, cmd_head[8]);
          bitcnt <= '0;
        end
        ST_ADDR, ST_WDATA: if (tick) begin
          sh     <= {sh[6:0], 1'b0};
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == 3'd7) st <= (st == ST_ADDR) ? ST_AACK : ST_WACK;
        end
        ST_AACK, ST_WACK: if (tick) st <= sda_in ? ST_STOP : ST_SEL;
        ST_SEL: begin
          if (cmd_empty) begin
            if (!hold_en) st <= ST_STOP;
          end else if (same_dir) begin
            bitcnt <= '0;
            if (cmd_head[8]) st <= ST_RDATA;
            else begin
              st <= ST_WDATA;
              sh <= cmd_head[7:0];
            end
          end else begin
            st <= restart_en ? ST_RSTART : ST_STOP;
          end
        end
        ST_RDATA: if (tick) begin
          sh     <= {sh[6:0], sda_in};
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == 3'd7) st <= ST_MACK;
        end
        ST_MACK: if (tick) st <= ST_SEL;
        ST_STOP: if (tick) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2cq_master.sv
module i2cq_master
  import i2cq_pkg::*;
#(
  parameter int CMD_DEPTH = 16,
  parameter int RX_DEPTH  = 16,
  parameter int EN_LAT    = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [8:0]  reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        bit_tick,
  input  logic        sda_in,
  output logic        bus_stb,
  output logic [2:0]  bus_sym,
  output logic        bus_bit
);
  localparam int CMD_W = 9;

  logic [7:0] ctrl_q, tar_q;
  logic       en_req, en_stat;
  logic       flag_tx_over, flag_rx_over, flag_tx_abort;

  logic             cmd_push_req, rx_pop, flags_rd;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [CMD_W-1:0] cmd_head;
  logic [7:0]       rx_dout, rx_byte;
  logic             cmd_pop, abort_evt, rx_push, busy, go, hold_en;

  assign cmd_push_req = reg_wr && (reg_addr == A_DATA);
  assign rx_pop       = reg_rd && (reg_addr == A_DATA) && !rx_empty;
  assign flags_rd     = reg_rd && (reg_addr == A_FLAGS);
  assign go           = en_stat && en_req && ctrl_q[C_MASTER];
  assign hold_en      = ctrl_q[C_STOPHOLD] && en_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q        <= '0;
      tar_q         <= '0;
      en_req        <= 1'b0;
      flag_tx_over  <= 1'b0;
      flag_rx_over  <= 1'b0;
      flag_tx_abort <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL)   ctrl_q <= reg_wdata[7:0];
      if (reg_wr && reg_addr == A_TARGET) tar_q  <= reg_wdata[7:0];
      if (reg_wr && reg_addr == A_ENABLE) en_req <= reg_wdata[0];
      flag_tx_over  <= (cmd_push_req && tx_full) || (flag_tx_over && !flags_rd);
      flag_rx_over  <= (rx_push && rx_full)      || (flag_rx_over && !flags_rd);
      flag_tx_abort <= abort_evt                 || (flag_tx_abort && !flags_rd);
    end
  end

  i2cq_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmdq (
    .clk(clk), .rst_n(rst_n), .push(cmd_push_req), .din(reg_wdata),
    .pop(cmd_pop), .flush(abort_evt), .dout(cmd_head),
    .full(tx_full), .empty(tx_empty)
  );

  i2cq_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_byte),
    .pop(rx_pop), .flush(1'b0), .dout(rx_dout),
    .full(rx_full), .empty(rx_empty)
  );

  i2cq_en_sync #(.LAT(EN_LAT)) u_en (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .busy(busy), .en_stat(en_stat)
  );

  i2cq_engine u_eng (
    .clk(clk), .rst_n(rst_n), .go(go), .hold_en(hold_en),
    .restart_en(ctrl_q[C_RESTART]), .tick(bit_tick), .sda_in(sda_in),
    .tar(tar_q), .cmd_empty(tx_empty), .cmd_head(cmd_head),
    .cmd_pop(cmd_pop), .abort_evt(abort_evt), .rx_push(rx_push),
    .rx_byte(rx_byte), .busy(busy), .bus_stb(bus_stb),
    .bus_sym(bus_sym), .bus_bit(bus_bit)
  );

  always_comb begin
    unique case (reg_addr)
      A_CTRL:   reg_rdata = {8'h00, ctrl_q};
      A_TARGET: reg_rdata = {8'h00, tar_q};
      A_DATA:   reg_rdata = rx_empty ? 16'h0000 : {8'h00, rx_dout};
      A_ENABLE: reg_rdata = {15'h0000, en_req};
      A_ENSTAT: reg_rdata = {15'h0000, en_stat};
      A_STATUS: reg_rdata = {10'h000, busy, 1'b0, !rx_empty, tx_empty, !tx_full,
                             busy || (go && !tx_empty)};
      A_FLAGS:  reg_rdata = {13'h0000, flag_tx_abort, flag_rx_over, flag_tx_over};
      default:  reg_rdata = 16'h0000;
    endcase
  end
endmodule

// File: rtl/i2cq_checker.sv
module i2cq_checker
  import i2cq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       bit_tick,
  input logic       bus_stb,
  input logic [2:0] bus_sym,
  input logic       busy,
  input logic       abort_evt,
  input logic       tx_empty,
  input logic       tx_full,
  input logic       cmd_push_req,
  input logic       flag_tx_over,
  input logic       rx_full,
  input logic       rx_push,
  input logic       flag_rx_over,
  input logic       flag_tx_abort,
  input logic       en_req,
  input logic       en_stat
);
  assert_strobe_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stb |-> bit_tick);

  assert_drop_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_push_req && tx_full) |=> flag_tx_over);

  assert_nack_flushes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (tx_empty && flag_tx_abort));

  assert_rx_drop_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full) |=> flag_rx_over);

  assert_idle_only_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(bus_stb && bus_sym == 3'(SYM_STOP)));

  assert_enable_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_stat) |-> $past(en_req));

  assert_disable_waits_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_stat) |-> $past(!en_req && !busy));
endmodule

bind i2cq_master i2cq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .bus_stb(bus_stb),
  .bus_sym(bus_sym), .busy(busy), .abort_evt(abort_evt), .tx_empty(tx_empty),
  .tx_full(tx_full), .cmd_push_req(cmd_push_req), .flag_tx_over(flag_tx_over),
  .rx_full(rx_full), .rx_push(rx_push), .flag_rx_over(flag_rx_over),
  .flag_tx_abort(flag_tx_abort), .en_req(en_req), .en_stat(en_stat)
);

// File: tb/tb_i2cq_master.sv
module tb_i2cq_master;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] S_START = 3'd1, S_RST = 3'd2, S_DRV = 3'd3, S_SMP = 3'd4, S_STOP = 3'd5;
  localparam logic [2:0] RA_CTRL = 3'd0, RA_TAR = 3'd1, RA_DATA = 3'd2, RA_EN = 3'd3,
                         RA_ENST = 3'd4, RA_STAT = 3'd5, RA_FLAG = 3'd6;
  localparam int LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, bit_tick = 0, sda_in = 1;
  logic [2:0] reg_addr = '0;
  logic [8:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic bus_stb, bus_bit;
  logic [2:0] bus_sym;

  int checks = 0, fails = 0;
  logic [7:0] tar_cfg = 8'hD5;
  logic [8:0] cmds [16];
  logic [7:0] rxv [17];

  i2cq_master dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] f_addr(input logic [7:0] t, input logic rd);
    return {t[6:0], rd};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [8:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic step(input logic sda, output logic stb, output logic [2:0] sym, output logic b);
    @(negedge clk); bit_tick = 1; sda_in = sda;
    #1 stb = bus_stb; sym = bus_sym; b = bus_bit;
    @(negedge clk); bit_tick = 0; sda_in = 1;
  endtask

  task automatic exp_sym(input logic sda, input logic [2:0] es, input logic eb, input string req);
    logic stb, b; logic [2:0] s;
    step(sda, stb, s, b);
    check(stb && s == es && (es != S_DRV || b == eb), req, {stb, s, b}, {1'b1, es, eb});
  endtask

  task automatic exp_quiet(input string req);
    logic stb, b; logic [2:0] s;
    step(1'b1, stb, s, b);
    check(!stb, req, stb, 0);
  endtask

  task automatic exp_addr(input logic rdb, input logic slave_nack);
    logic [7:0] a = f_addr(tar_cfg, rdb);
    for (int i = 7; i >= 0; i--) exp_sym(1'b1, S_DRV, a[i], "R11 address bit");
    exp_sym(slave_nack, S_SMP, 1'b0, "R3 address ack slot");
  endtask

  task automatic exp_wbyte(input logic [7:0] v, input logic slave_nack);
    for (int i = 7; i >= 0; i--) exp_sym(1'b1, S_DRV, v[i], "R3 write bit");
    exp_sym(slave_nack, S_SMP, 1'b0, "R3 data ack slot");
  endtask

  task automatic exp_rbyte(input logic [7:0] v, input logic mnack);
    for (int i = 7; i >= 0; i--) exp_sym(v[i], S_SMP, 1'b0, "R5 read bit");
    exp_sym(1'b1, S_DRV, mnack, "R6 master ack level");
  endtask

  task automatic wait_enstat(input logic want);
    logic [15:0] d;
    int n = 0;
    do begin rd(RA_ENST, d); n++; end while (d[0] != want && n < 12);
    check(d[0] == want, "R2 enable status follows", d[0], want);
  endtask

  // plays cmds[0..n-1] through the bus using the bench model of R3, R5-R8
  task automatic play(input int n, input bit rs);
    int nrx = 0;
    logic [15:0] d;
    for (int i = 0; i < n; i++) wr(RA_DATA, cmds[i]);
    exp_sym(1'b1, S_START, 1'b0, "R3 start");
    exp_addr(cmds[0][8], 1'b0);
    for (int i = 0; i < n; i++) begin
      if (i > 0 && cmds[i][8] != cmds[i-1][8]) begin
        if (rs) exp_sym(1'b1, S_RST, 1'b0, "R7 repeated start");
        else begin
          exp_sym(1'b1, S_STOP, 1'b0, "R7 stop on turn");
          exp_sym(1'b1, S_START, 1'b0, "R7 new start");
        end
        exp_addr(cmds[i][8], 1'b0);
      end
      if (cmds[i][8]) begin
        logic mn;
        rxv[nrx] = 8'($urandom);
        mn = (i == n - 1) ? 1'b1 : !cmds[i+1][8];
        exp_rbyte(rxv[nrx], mn);
        nrx++;
      end else exp_wbyte(cmds[i][7:0], 1'b0);
    end
    exp_sym(1'b1, S_STOP, 1'b0, "R8 stop when queue empties");
    for (int j = 0; j < nrx; j++) begin
      rd(RA_DATA, d);
      check(d[7:0] == rxv[j], "R5 received byte order", d[7:0], rxv[j]);
    end
  endtask

  initial begin
    logic [15:0] d;
    void'($urandom(32'h1C0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(RA_STAT, d); check(d == 16'h006, "R1 status after reset", d, 16'h006);
    rd(RA_ENST, d); check(d == 16'h000, "R1 enable status after reset", d, 0);
    rd(RA_FLAG, d); check(d == 16'h000, "R1 flags after reset", d, 0);

    wr(RA_CTRL, 9'h063);
    wr(RA_TAR, {1'b0, tar_cfg});
    wr(RA_EN, 9'h001);
    rd(RA_ENST, d); check(d[0] == 1'b0, "R2 enable not immediate", d[0], 0);
    wait_enstat(1'b1);

    // random mixed command lists, restart on then off
    for (int k = 0; k < 8; k++) begin
      int n = 1 + int'($urandom_range(5));
      for (int i = 0; i < n; i++) cmds[i] = 9'($urandom);
      wr(RA_CTRL, (k < 4) ? 9'h063 : 9'h043);
      play(n, k < 4);
      rd(RA_STAT, d); check(d[5] == 1'b0 && d[3] == 1'b0, "R5 idle and rx empty", d, 0);
    end

    // directed: read followed by write gets NACK, restart on
    wr(RA_CTRL, 9'h063);
    cmds[0] = 9'h100; cmds[1] = 9'h100; cmds[2] = 9'h03C; cmds[3] = 9'h100;
    play(4, 1'b1);

    // stop-hold keeps the bus, later push continues, clearing releases
    wr(RA_CTRL, 9'h0E3);
    wr(RA_DATA, 9'h0A5);
    exp_sym(1'b1, S_START, 1'b0, "R8 start");
    exp_addr(1'b0, 1'b0);
    exp_wbyte(8'hA5, 1'b0);
    for (int i = 0; i < 3; i++) exp_quiet("R8 bus held");
    rd(RA_STAT, d); check(d[5] == 1'b1, "R8 master active while held", d[5], 1);
    wr(RA_DATA, 9'h05A);
    exp_wbyte(8'h5A, 1'b0);
    exp_quiet("R8 held again");
    wr(RA_CTRL, 9'h063);
    exp_sym(1'b1, S_STOP, 1'b0, "R8 stop after release");

    // slave NACK on address
    for (int i = 0; i < 3; i++) wr(RA_DATA, 9'(8'h10 + i));
    exp_sym(1'b1, S_START, 1'b0, "R9 start");
    exp_addr(1'b0, 1'b1);
    exp_sym(1'b1, S_STOP, 1'b0, "R9 stop after address nack");
    rd(RA_STAT, d); check(d[2] == 1'b1, "R9 queue flushed", d[2], 1);
    rd(RA_FLAG, d); check(d[2:0] == 3'b100, "R9 abort flag", d[2:0], 4);
    rd(RA_FLAG, d); check(d[2:0] == 3'b000, "R12 flags cleared by read", d[2:0], 0);
    // slave NACK on data
    wr(RA_DATA, 9'h077); wr(RA_DATA, 9'h088);
    exp_sym(1'b1, S_START, 1'b0, "R9 start");
    exp_addr(1'b0, 1'b0);
    exp_wbyte(8'h77, 1'b1);
    exp_sym(1'b1, S_STOP, 1'b0, "R9 stop after data nack");
    rd(RA_STAT, d); check(d[2] == 1'b1, "R9 queue flushed on data nack", d[2], 1);
    rd(RA_FLAG, d); check(d[2] == 1'b1, "R9 abort flag data", d[2], 1);

    // command queue overflow with the master switched off
    wr(RA_CTRL, 9'h062);
    for (int i = 0; i < 17; i++) begin cmds[i % 16] = (i < 16) ? 9'($urandom_range(255)) : cmds[i % 16]; wr(RA_DATA, (i < 16) ? cmds[i] : 9'h0FF); end
    rd(RA_STAT, d); check(d[1] == 1'b0, "R4 queue full", d[1], 0);
    rd(RA_FLAG, d); check(d[0] == 1'b1, "R4 overflow flag", d[0], 1);
    for (int i = 0; i < 2; i++) exp_quiet("R12 no start while master off");
    wr(RA_CTRL, 9'h063);
    exp_sym(1'b1, S_START, 1'b0, "R4 start");
    exp_addr(1'b0, 1'b0);
    for (int i = 0; i < 16; i++) exp_wbyte(cmds[i][7:0], 1'b0);
    exp_sym(1'b1, S_STOP, 1'b0, "R4 exactly 16 kept");

    // receive overflow
    for (int i = 0; i < 16; i++) wr(RA_DATA, 9'h100);
    exp_sym(1'b1, S_START, 1'b0, "R10 start");
    exp_addr(1'b1, 1'b0);
    for (int i = 0; i < 16; i++) begin rxv[i] = 8'($urandom); exp_rbyte(rxv[i], i == 15); end
    exp_sym(1'b1, S_STOP, 1'b0, "R10 stop");
    wr(RA_DATA, 9'h100);
    exp_sym(1'b1, S_START, 1'b0, "R10 start 2");
    exp_addr(1'b1, 1'b0);
    exp_rbyte(8'hEE, 1'b1);
    exp_sym(1'b1, S_STOP, 1'b0, "R10 stop 2");
    rd(RA_FLAG, d); check(d[1] == 1'b1, "R10 rx overflow flag", d[1], 1);
    for (int i = 0; i < 16; i++) begin
      rd(RA_DATA, d); check(d[7:0] == rxv[i], "R10 older bytes kept", d[7:0], rxv[i]);
    end
    rd(RA_STAT, d); check(d[3] == 1'b0, "R5 rx drained", d[3], 0);

    // disable while the bus is held
    wr(RA_CTRL, 9'h0E3);
    wr(RA_DATA, 9'h0C3);
    exp_sym(1'b1, S_START, 1'b0, "R2 start");
    exp_addr(1'b0, 1'b0);
    exp_wbyte(8'hC3, 1'b0);
    wr(RA_EN, 9'h000);
    repeat (LAT + 3) @(negedge clk);
    rd(RA_ENST, d); check(d[0] == 1'b1, "R2 disable waits for stop", d[0], 1);
    exp_sym(1'b1, S_STOP, 1'b0, "R2 stop on disable");
    wait_enstat(1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule